// File: doc/BRIEF.md
# Die Thermal Warning and Shutdown Controller

This block watches a digital die-temperature reading, given in whole degrees Celsius as a signed value, and turns it into protection signals. Three warning levels each set at a trip point and clear at a release point 10 degrees lower. The levels drive a count of requested gain-reduction steps. They also appear in bits 5, 6 and 7 of a status byte, which a host can read at any time, shutdown included.

A separate shutdown detector trips at 155 degrees. It latches an over-temperature shutdown that raises the fault output and asks the output stage to go to high impedance. Cooling alone never ends the shutdown. The die must first fall below the 145-degree release point, and then a host restart pulse clears the latch. A restart that arrives while the die is still hot is ignored.

Top module: `thermal_guard`

## Requirements
- R1: After reset all warning levels, the status byte, the gain-step count, shutdown, fault and high-impedance request are zero.
- R2: Warning level 1, 2 or 3 becomes active on the clock edge that samples a temperature at or above 125, 135 or 145 degrees respectively.
- R3: An active warning level stays active while the temperature is at or above its release point (115, 125, 135 degrees for levels 1, 2, 3) and clears on the edge that samples a temperature below it.
- R4: Status bit 5 shows level 1, bit 6 level 2 and bit 7 level 3; bits 0 to 4 read zero. The warning output equals level 1, and a higher level is never active without all lower levels.
- R5: The gain-step output is the number of active warning levels (0 to 3).
- R6: A temperature at or above 155 degrees latches shutdown within two clock edges. While latched, the fault output and the high-impedance request are high, and the latch holds as the temperature falls.
- R7: A restart pulse is ignored while the shutdown detector is still hot, that is, from the trip until a temperature below 145 degrees has been sampled.
- R8: A restart pulse after the temperature has fallen below 145 degrees clears shutdown, fault and high-impedance request. A restart pulse with no shutdown latched changes nothing.
- R9: Warning levels and status bits keep tracking the temperature while shutdown is latched.
- R10: The reading is signed two's complement, so negative temperatures count as below every threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_i | input | 9 | Signed die temperature in degrees Celsius |
| restart_i | input | 1 | Host restart pulse, one cycle |
| warn_o | output | 1 | Any warning active (level 1) |
| warn_lvl_o | output | 3 | Active warning levels, bit 0 is level 1 |
| gain_step_o | output | 2 | Number of gain-reduction steps requested |
| status_o | output | 8 | Status byte, levels in bits 7:5 |
| shutdown_o | output | 1 | Over-temperature shutdown latched |
| fault_o | output | 1 | Fault indication |
| hiz_o | output | 1 | Output-stage high-impedance request |

## Verification
The bench probes each threshold at exactly the trip value and one degree below it, and each release point at exactly the release value and one degree below it. A comparator with an off-by-one or a swapped strict/inclusive compare would set or clear a level one degree away from where it should. Restart pulses arrive at 150 and at exactly 145 degrees, where a design keyed on the current temperature instead of the detector's hot state, or one with no host gate at all, would drop shutdown too early. It also sends a restart with nothing latched and applies negative readings, where an unsigned compare would see a huge value and trip every level.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
    localparam int NUM_LVL = 3;
    localparam int STEP_W  = $clog2(NUM_LVL + 1);

    typedef struct packed {
        logic shut;
    } latch_state_t;
endpackage

// File: rtl/thermal_hyst_det.sv
module thermal_hyst_det #(
    parameter int TEMP_W = 9,
    parameter int TRIP   = 125,
    parameter int REL    = 115
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TEMP_W-1:0] temp_i,
    output logic                     active_o
);
    localparam logic signed [TEMP_W-1:0] TRIP_V = TRIP[TEMP_W-1:0];
    localparam logic signed [TEMP_W-1:0] REL_V  = REL[TEMP_W-1:0];

    logic act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (temp_i >= TRIP_V)
            act_d = 1'b1;
        else if (temp_i < REL_V)
            act_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_d;
    end

    assign active_o = act_q;

    // R2: reaching the trip point sets the state on the next edge
    a_r2_trip_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_i >= TRIP_V) |=> active_o);

    // R3: active state held while at or above release
    a_r3_hold_above_rel: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && temp_i >= REL_V) |=> active_o);

    // R3: below release clears it
    a_r3_clear_below_rel: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_i < REL_V) |=> !active_o);
endmodule

// File: rtl/thermal_sd_latch.sv
module thermal_sd_latch
    import thermal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    input  logic restart_i,
    output logic shut_o
);
    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hot_i)
            st_d.shut = 1'b1;
        else if (restart_i)
            st_d.shut = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shut_o = st_q.shut;

    // R6: a hot detector always leads to a latched shutdown
    a_r6_hot_latches: assert property (@(posedge clk) disable iff (!rst_n)
        hot_i |=> shut_o);

    // R6: without a restart the latch never drops
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_o && !restart_i) |=> shut_o);

    // R7: restart while hot is ignored
    a_r7_restart_hot_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_o && hot_i && restart_i) |=> shut_o);

    // R8: restart with no latch leaves it clear unless heat arrives
    a_r8_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!shut_o && !hot_i && restart_i) |=> !shut_o);
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_pkg::*;
#(
    parameter int TEMP_W     = 9,
    parameter int WARN1_TRIP = 125,
    parameter int WARN2_TRIP = 135,
    parameter int WARN3_TRIP = 145,
    parameter int WARN_HYST  = 10,
    parameter int SD_TRIP    = 155,
    parameter int SD_REL     = 145,
    parameter int STATUS_W   = 8,
    parameter int WARN_LSB   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [TEMP_W-1:0] temp_i,
    input  logic                     restart_i,
    output logic                     warn_o,
    output logic [NUM_LVL-1:0]       warn_lvl_o,
    output logic [STEP_W-1:0]        gain_step_o,
    output logic [STATUS_W-1:0]      status_o,
    output logic                     shutdown_o,
    output logic                     fault_o,
    output logic                     hiz_o
);
    logic [NUM_LVL-1:0] lvl;
    logic               sd_hot;
    logic               shut;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        localparam int TRIP_G = (g == 0) ? WARN1_TRIP :
                                (g == 1) ? WARN2_TRIP : WARN3_TRIP;
        thermal_hyst_det #(
            .TEMP_W (TEMP_W),
            .TRIP   (TRIP_G),
            .REL    (TRIP_G - WARN_HYST)
        ) u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .temp_i   (temp_i),
            .active_o (lvl[g])
        );
    end

    thermal_hyst_det #(
        .TEMP_W (TEMP_W),
        .TRIP   (SD_TRIP),
        .REL    (SD_REL)
    ) u_sd_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .temp_i   (temp_i),
        .active_o (sd_hot)
    );

    thermal_sd_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .hot_i     (sd_hot),
        .restart_i (restart_i),
        .shut_o    (shut)
    );

    always_comb begin
        gain_step_o = '0;
        for (int i = 0; i < NUM_LVL; i++)
            gain_step_o = gain_step_o + STEP_W'(lvl[i]);
        status_o = '0;
        status_o[WARN_LSB +: NUM_LVL] = lvl;
    end

    assign warn_lvl_o = lvl;
    assign warn_o     = lvl[0];
    assign shutdown_o = shut;
    assign fault_o    = shut;
    assign hiz_o      = shut;

    // R4: levels from separate detectors form a thermometer code
    a_r4_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl[2] |-> lvl[1]) and (lvl[1] |-> lvl[0]));

    // R6: shutdown detector hot implies the top reports shutdown next cycle
    a_r6_sd_visible: assert property (@(posedge clk) disable iff (!rst_n)
        sd_hot |=> (shutdown_o && hiz_o && fault_o));
endmodule

// File: tb/thermal_guard_test.sv
module thermal_guard_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic signed [8:0] temp = 9'sd25;
    logic              restart = 1'b0;
    logic              warn;
    logic [2:0]        lvl;
    logic [1:0]        step;
    logic [7:0]        status;
    logic              shutdown, fault, hiz;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    thermal_guard uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .temp_i      (temp),
        .restart_i   (restart),
        .warn_o      (warn),
        .warn_lvl_o  (lvl),
        .gain_step_o (step),
        .status_o    (status),
        .shutdown_o  (shutdown),
        .fault_o     (fault),
        .hiz_o       (hiz)
    );

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic set_temp(input int t);
        @(negedge clk);
        temp = 9'(t);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_levels(input string req, input int exp_lvl);
        int n;
        n = 0;
        for (int i = 0; i < 3; i++) n += (exp_lvl >> i) & 1;
        check({req, " levels"}, lvl, exp_lvl);
        check({req, " status"}, status, exp_lvl << 5);
        check({req, " warn"}, warn, exp_lvl & 1);
        check({req, " R5 step"}, step, n);
    endtask

    task automatic check_shut(input string req, input int exp);
        check({req, " shutdown"}, shutdown, exp);
        check({req, " fault"}, fault, exp);
        check({req, " hiz"}, hiz, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_levels("R1 reset", 0);
        check_shut("R1 reset", 0);
    endtask

    task automatic t_heat();
        set_temp(124); check_levels("R2 at 124", 3'b000);
        set_temp(125); check_levels("R2 R4 at 125", 3'b001);
        set_temp(134); check_levels("R2 at 134", 3'b001);
        set_temp(135); check_levels("R2 at 135", 3'b011);
        set_temp(144); check_levels("R2 at 144", 3'b011);
        set_temp(145); check_levels("R2 at 145", 3'b111);
        check_shut("R6 no trip at 145", 0);
    endtask

    task automatic t_cool();
        set_temp(135); check_levels("R3 at 135", 3'b111);
        set_temp(134); check_levels("R3 at 134", 3'b011);
        set_temp(125); check_levels("R3 at 125", 3'b011);
        set_temp(124); check_levels("R3 at 124", 3'b001);
        set_temp(115); check_levels("R3 at 115", 3'b001);
        set_temp(114); check_levels("R3 at 114", 3'b000);
    endtask

    task automatic t_shutdown();
        set_temp(154); check_shut("R6 at 154", 0);
        set_temp(155); check_shut("R6 at 155", 1);
        check_levels("R9 at 155", 3'b111);
        set_temp(150); check_shut("R6 held at 150", 1);
        pulse_restart(); check_shut("R7 restart at 150", 1);
        set_temp(145); pulse_restart(); check_shut("R7 restart at 145", 1);
        set_temp(144); check_shut("R6 held at 144", 1);
        set_temp(100); check_levels("R9 during shutdown", 3'b000);
        check_shut("R9 still shut", 1);
        pulse_restart(); check_shut("R8 restart cool", 0);
    endtask

    task automatic t_idle_restart();
        set_temp(130);
        pulse_restart();
        check_shut("R8 idle restart", 0);
        check_levels("R8 idle restart", 3'b001);
    endtask

    task automatic t_negative();
        set_temp(-40); check_levels("R10 at -40", 3'b000);
        check_shut("R10 at -40", 0);
        set_temp(-1); check_levels("R10 at -1", 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_heat();
        t_cool();
        t_shutdown();
        t_idle_restart();
        t_negative();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule